// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave (Read Path)

This block models a small serial EEPROM that answers a two-wire bus whose clock and data lines are not seen continuously but as sampled levels. Each time the bus master updates the lines, it pulses `strobe` for one clock with the new `scl_in` and `sda_in` levels. The slave compares each sample with the previous one. From that comparison it recognises start and stop conditions, captures bits on clock rising transitions, and answers on `sda_out`.

A transfer moves through fixed phases counted by a tick counter. First comes a command byte, whose last bit selects read (1) or write (0), followed by an acknowledge. Then a second byte follows. Under a write command that byte is taken as the memory address, and the addressed byte is fetched. Under a read command the fetched byte is shifted out most significant bit first. An acknowledge closes the second byte as well. A typical random read is: start, write command, address, repeated start, read command, eight data clocks. The storage is read-only and is preloaded from a parameter image. It holds 256 bytes with an 8-bit address, or 128 bytes with a 7-bit address.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_out` is 1 and `bit_err` is 0, and both lines are taken as idle-high.
- R2: A strobe with SCL high in both the previous and the new sample and a changed SDA is a bus condition. SDA falling is a start, which arms the command phase. SDA rising is a stop, which returns to idle. Both cancel a pending acknowledge.
- R3: With no transfer armed and no acknowledge pending, every strobe except a start leaves `sda_out` at 1 and `bit_err` at 0.
- R4: A bit is taken on an SCL low-to-high strobe whose SDA equals the previous SDA. Eight such bits after a start form the command byte, MSB first, and its last bit selects read when 1.
- R5: On the first SCL rising strobe after the eighth command bit, and again after the eighth bit of the second byte, `sda_out` is driven 0 (acknowledge) and no bit is taken.
- R6: Under a write command the next eight bits are shifted MSB first into the address register. On the eighth bit the data register is loaded from the image at that address.
- R7: Under a read command each of the next eight SCL rising strobes drives `sda_out` with the next data bit, MSB first.
- R8: Every strobe that drives neither an acknowledge nor a read bit sets `sda_out` to 1, and `sda_out` does not change in a cycle without a strobe.
- R9: An SCL rising strobe whose SDA differs from the previous SDA, with no acknowledge pending during a transfer, raises `bit_err` for one cycle and takes no bit.
- R10: With `ADDR_W` = 7 only the last seven address bits received are kept, so the address wraps modulo 128.
- R11: Image byte i lives at `INIT_IMAGE[8*i +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | One-cycle pulse: new bus levels are valid |
| scl_in | input | 1 | Sampled clock line level |
| sda_in | input | 1 | Sampled data line level driven by the master |
| sda_out | output | 1 | Slave data drive, 1 = released |
| bit_err | output | 1 | One-cycle pulse on an SDA change at an SCL rise |

## Verification
A single SCL rising strobe can carry both a data-line change and a pending acknowledge. The acknowledge must win and no error may be flagged. Outside an acknowledge, the same change must raise `bit_err` and leave the bit count unchanged. The bench provokes the skew case in the middle of an address byte and then completes the random read. The returned data byte is the judge: a shifted-in skew bit would select the wrong image byte. Acknowledge clocks are scored for a low `sda_out` with `bit_err` low.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

   localparam int unsigned BYTE_W = 8;

   // classification of one strobe against the previous sample
   typedef enum logic [2:0] {
      EV_NONE,
      EV_START,
      EV_STOP,
      EV_RISE_OK,
      EV_RISE_SKEW,
      EV_OTHER
   } bus_ev_e;

   // default preload image, 256 bytes
   function automatic logic [2047:0] seed_image();
      logic [2047:0] img;
      img = '0;
      for (int i = 0; i < 256; i++) begin
         img[i*8 +: 8] = 8'(i * 29 + 7) ^ 8'(i >> 2);
      end
      return img;
   endfunction

endpackage

// File: rtl/i2cee_line_sampler.sv
module i2cee_line_sampler
   import i2cee_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    strobe,
   input  logic    scl_in,
   input  logic    sda_in,
   output bus_ev_e ev
);

   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else if (strobe) begin
         scl_q <= scl_in;
         sda_q <= sda_in;
      end
   end

   always_comb begin
      if (!strobe) begin
         ev = EV_NONE;
      end else if (scl_q && scl_in && (sda_q != sda_in)) begin
         ev = sda_in ? EV_STOP : EV_START;
      end else if (!scl_q && scl_in) begin
         ev = (sda_q == sda_in) ? EV_RISE_OK : EV_RISE_SKEW;
      end else begin
         ev = EV_OTHER;
      end
   end

endmodule

// File: rtl/i2cee_image_rom.sv
module i2cee_image_rom #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DEPTH  = 1 << ADDR_W,
   parameter logic [DEPTH*8-1:0] INIT_IMAGE = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [7:0]        rd_byte
);

   logic [7:0] mem [DEPTH];

   generate
      if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_width
         $error("i2cee_image_rom: ADDR_W must lie in 2..8");
      end
      if (DEPTH != (1 << ADDR_W)) begin : g_bad_depth
         $error("i2cee_image_rom: DEPTH must equal 2**ADDR_W");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
         assign mem[g] = INIT_IMAGE[g*8 +: 8];
      end
   endgenerate

   assign rd_byte = mem[addr];

endmodule

// File: rtl/i2cee_seq.sv
module i2cee_seq
   import i2cee_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  bus_ev_e           ev,
   input  logic              sda_in,
   input  logic [7:0]        rom_q,
   output logic [ADDR_W-1:0] rom_addr,
   output logic              sda_out,
   output logic              bit_err
);

   localparam int unsigned CMD_END  = BYTE_W + 1;          // tick after command byte
   localparam int unsigned DATA_END = 2 * BYTE_W + 1;      // tick after second byte
   localparam int unsigned TICK_W   = $clog2(DATA_END + 1);

   logic [TICK_W-1:0] tick;
   logic              ack_pend;
   logic              rd_mode;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W:0]   addr_cat;
   logic [ADDR_W-1:0] addr_nx;
   logic [7:0]        shreg;
   logic              idle, rising, in_cmd;

   assign addr_cat = {addr_q, sda_in};
   assign addr_nx  = addr_cat[ADDR_W-1:0];
   assign rom_addr = rd_mode ? addr_q : addr_nx;
   assign idle     = (tick == '0) && !ack_pend;
   assign rising   = (ev == EV_RISE_OK) || (ev == EV_RISE_SKEW);
   assign in_cmd   = tick < TICK_W'(CMD_END);

   always_ff @(posedge clk) begin
      if (rst) begin
         tick     <= '0;
         ack_pend <= 1'b0;
         rd_mode  <= 1'b0;
         addr_q   <= '0;
         shreg    <= '0;
         sda_out  <= 1'b1;
         bit_err  <= 1'b0;
      end else begin
         bit_err <= 1'b0;
         if (ev != EV_NONE) begin
            sda_out <= 1'b1;
            if (ev == EV_START) begin
               tick     <= TICK_W'(1);
               ack_pend <= 1'b0;
            end else if (ev == EV_STOP) begin
               tick     <= '0;
               ack_pend <= 1'b0;
            end else if (idle) begin
               tick <= tick;
            end else if (rising) begin
               if (ack_pend) begin
                  sda_out  <= 1'b0;
                  ack_pend <= 1'b0;
               end else if (ev == EV_RISE_SKEW) begin
                  bit_err <= 1'b1;
               end else if (in_cmd) begin
                  rd_mode <= sda_in;
                  tick    <= tick + 1'b1;
                  if (tick == TICK_W'(CMD_END - 1)) ack_pend <= 1'b1;
               end else begin
                  if (rd_mode) begin
                     sda_out <= shreg[7];
                     shreg   <= {shreg[6:0], 1'b0};
                  end else begin
                     addr_q <= addr_nx;
                  end
                  if (tick == TICK_W'(DATA_END - 1)) begin
                     shreg    <= rom_q;
                     ack_pend <= 1'b1;
                     tick     <= '0;
                  end else begin
                     tick <= tick + 1'b1;
                  end
               end
            end
         end
      end
   end

   a_r2_start_arms : assert property (@(posedge clk) disable iff (rst)
      (ev == EV_START) |=> (tick == TICK_W'(1) && !ack_pend));

   a_r3_idle_quiet : assert property (@(posedge clk) disable iff (rst)
      (idle && ev != EV_NONE && ev != EV_START) |=> (sda_out && !bit_err && tick == '0));

   a_r5_ack_low : assert property (@(posedge clk) disable iff (rst)
      (ack_pend && rising) |=> (!sda_out && !bit_err));

   a_r8_hold : assert property (@(posedge clk) disable iff (rst)
      (ev == EV_NONE) |=> $stable(sda_out));

   a_r9_skew_no_shift : assert property (@(posedge clk) disable iff (rst)
      (ev == EV_RISE_SKEW && !ack_pend && tick != '0) |=> ($stable(tick) && bit_err));

   a_r4_tick_range : assert property (@(posedge clk) disable iff (rst)
      tick < TICK_W'(DATA_END));

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
   parameter int unsigned ADDR_W = 8,
   parameter logic [(1 << ADDR_W)*8-1:0] INIT_IMAGE =
      ((1 << ADDR_W)*8)'(i2cee_pkg::seed_image())
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_out,
   output logic bit_err
);

   import i2cee_pkg::*;

   localparam int unsigned DEPTH = 1 << ADDR_W;

   bus_ev_e           ev;
   logic [ADDR_W-1:0] rom_addr;
   logic [7:0]        rom_q;

   i2cee_line_sampler u_sampler (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .scl_in (scl_in),
      .sda_in (sda_in),
      .ev     (ev)
   );

   i2cee_image_rom #(
      .ADDR_W     (ADDR_W),
      .DEPTH      (DEPTH),
      .INIT_IMAGE (INIT_IMAGE)
   ) u_rom (
      .addr    (rom_addr),
      .rd_byte (rom_q)
   );

   i2cee_seq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .ev       (ev),
      .sda_in   (sda_in),
      .rom_q    (rom_q),
      .rom_addr (rom_addr),
      .sda_out  (sda_out),
      .bit_err  (bit_err)
   );

   a_r9_err_needs_strobe : assert property (@(posedge clk) disable iff (rst)
      !strobe |=> !bit_err);

endmodule

// File: tb/tb_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_slave;

   function automatic logic [2047:0] make_img();
      logic [2047:0] v;
      v = '0;
      for (int i = 0; i < 256; i++) v[i*8 +: 8] = 8'(i * 53 + 100) ^ 8'(i >> 4);
      return v;
   endfunction

   localparam logic [2047:0] IMG  = make_img();
   localparam logic [1023:0] IMGN = IMG[1023:0];

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic strobe = 1'b0;
   logic scl = 1'b1;
   logic sda = 1'b1;
   logic sda_w, err_w, sda_n, err_n;

   always #2 clk = ~clk;   // 250 MHz

   i2c_eeprom_slave #(.ADDR_W(8), .INIT_IMAGE(IMG)) dut (
      .clk(clk), .rst(rst), .strobe(strobe), .scl_in(scl), .sda_in(sda),
      .sda_out(sda_w), .bit_err(err_w));

   i2c_eeprom_slave #(.ADDR_W(7), .INIT_IMAGE(IMGN)) dut_narrow (
      .clk(clk), .rst(rst), .strobe(strobe), .scl_in(scl), .sda_in(sda),
      .sda_out(sda_n), .bit_err(err_n));

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   logic  q_w[$];
   logic  q_n[$];
   logic  q_e[$];
   string q_t[$];

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // driver: one bus update, expected results pushed to the scoreboard
   task automatic bus(input logic c, input logic d, input logic ew, input logic en,
                      input logic ee, input string tag);
      @(negedge clk);
      scl = c; sda = d; strobe = 1'b1;
      q_w.push_back(ew); q_n.push_back(en); q_e.push_back(ee); q_t.push_back(tag);
      @(negedge clk);
      strobe = 1'b0;
   endtask

   // monitor: compares each strobe's outcome, and holding between strobes
   initial begin
      logic was, last_w, last_n;
      last_w = 1'b1; last_n = 1'b1;
      forever begin
         @(posedge clk);
         was = strobe;
         #1;
         if (!rst && was) begin
            logic ew, en, ee; string t;
            ew = q_w.pop_front(); en = q_n.pop_front(); ee = q_e.pop_front(); t = q_t.pop_front();
            vectors++;
            if (sda_w !== ew || sda_n !== en || err_w !== ee || err_n !== ee) begin
               miscompares++;
               $display("FAIL %s: sda=%b/%b err=%b/%b expected sda=%b/%b err=%b",
                        t, sda_w, sda_n, err_w, err_n, ew, en, ee);
            end
            last_w = sda_w; last_n = sda_n;
         end else if (!rst) begin
            vectors++;
            if (sda_w !== last_w || sda_n !== last_n || err_w !== 1'b0) begin
               miscompares++;
               $display("FAIL R8 hold: sda=%b/%b err=%b expected sda=%b/%b err=0",
                        sda_w, sda_n, err_w, last_w, last_n);
            end
         end
      end
   end

   task automatic clk_bit(input logic b, input string tag);
      bus(1'b0, b, 1'b1, 1'b1, 1'b0, "R8");
      bus(1'b1, b, 1'b1, 1'b1, 1'b0, tag);
   endtask

   task automatic send_byte(input logic [7:0] v, input string tag);
      for (int i = 7; i >= 0; i--) clk_bit(v[i], tag);
   endtask

   task automatic ack_clk(input string tag);
      bus(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
      bus(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic start_cond();
      bus(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
      bus(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
      bus(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
   endtask

   task automatic stop_cond();
      bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
      bus(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
      bus(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
   endtask

   task automatic read_data(input logic [7:0] a);
      logic [6:0] an;
      an = a[6:0];
      for (int i = 7; i >= 0; i--) begin
         bus(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
         bus(1'b1, 1'b1, IMG[a*8 + i], IMGN[an*8 + i], 1'b0, "R7 R10 R11 data bit");
      end
   endtask

   task automatic random_read(input logic [7:0] a, input bit skew);
      start_cond();
      send_byte(8'hA0, "R4 command");
      ack_clk("R5 command ack");
      for (int i = 7; i >= 0; i--) begin
         if (skew && i == 4) begin
            bus(1'b0, ~a[i], 1'b1, 1'b1, 1'b0, "R8");
            bus(1'b1, a[i], 1'b1, 1'b1, 1'b1, "R9 skew flagged");
         end
         clk_bit(a[i], "R6 address");
      end
      ack_clk("R5 address ack");
      start_cond();
      send_byte(8'hA1, "R4 read command");
      ack_clk("R5 read ack");
      read_data(a);
      ack_clk("R5 closing ack");
      stop_cond();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      vectors++;
      if (sda_w !== 1'b1 || err_w !== 1'b0 || sda_n !== 1'b1 || err_n !== 1'b0) begin
         miscompares++;
         $display("FAIL R1 reset: sda=%b err=%b expected sda=1 err=0", sda_w, err_w);
      end

      // R3: activity without a start, including a skewed rise, is ignored
      bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
      bus(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
      bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
      bus(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R3 skew while idle");
      for (int k = 0; k < 10; k++) clk_bit(1'b0, "R3 no ack while idle");

      random_read(8'h00, 1'b0);
      random_read(8'h5C, 1'b0);
      random_read(8'hFF, 1'b0);   // R10: narrow instance reads byte 0x7F
      random_read(8'hA7, 1'b1);   // R9: skew inside the address byte

      // R2: stop in the middle of a command cancels the transfer
      start_cond();
      clk_bit(1'b1, "R4"); clk_bit(1'b0, "R4"); clk_bit(1'b1, "R4");
      stop_cond();
      for (int k = 0; k < 10; k++) clk_bit(1'b1, "R2 no ack after stop");

      random_read(8'h81, 1'b0);
      repeat (4) @(negedge clk);
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
   end

endmodule